// File: doc/BRIEF.md
# Three-Port Queue and Mailbox Access Decoder

This block sits between the control pins of a three-port queue device and its storage. Each port has its own clock and its own small set of control inputs, and the block turns them into access strobes for two queues and two single-word mailboxes. Queue 1 carries words from port A to port B, and queue 2 carries words from port C to port A. Mailbox 1 follows the same path as queue 1, and mailbox 2 the same path as queue 2.

Port A works in both directions. It can push queue 1, pop queue 2, write mailbox 1 or read mailbox 2. Port B only reads, from queue 1 or from mailbox 1. Port C only writes, to queue 2 or to mailbox 2. The block also produces a drive-enable output for port A and one for port B, which the pad logic uses to turn the output buffers on.

All decode paths are combinational. A strobe is therefore valid in time to be sampled on the same rising edge of its port clock, and it lasts one cycle for each cycle its enabling condition holds. The readiness flags come from the flag logic outside this block. There is no data path inside this block, so no valid/ready back-pressure applies. The readiness flags take that role: a queue strobe is withheld while its flag is low. Mailbox strobes ignore the flags.

Top module: `tri_port_access_dec`

## Requirements
- R1: `a_drv_en` is 1 exactly when `a_sel_n` is 0 and `a_dir_wr` is 0. It does not depend on `a_en` or `a_mbx`.
- R2: `q1_push` is 1 exactly when port A is active (`a_sel_n`=0 and `a_en`=1), `a_dir_wr`=1, `a_mbx`=0 and `q1_room`=1.
- R3: `q2_pop_a` is 1 exactly when port A is active, `a_dir_wr`=0, `a_mbx`=0 and `q2_avail_a`=1.
- R4: On port A, with `a_mbx`=1, `mb1_wr_a` fires when the port is active with `a_dir_wr`=1, and `mb2_rd_a` fires when the port is active with `a_dir_wr`=0. Both ignore the readiness flags.
- R5: `b_drv_en` is 1 exactly when `b_sel_n` is 0, whatever the state of `b_rd_en` and `b_mbx`.
- R6: `q1_pop_b` fires when `b_sel_n`=0, `b_rd_en`=1, `b_mbx`=0 and `q1_avail_b`=1. `mb1_rd_b` fires when `b_sel_n`=0, `b_rd_en`=1 and `b_mbx`=1, whatever the flag.
- R7: `q2_push_c` fires when `c_wr_en`=1, `c_mbx`=0 and `q2_room_c`=1. `mb2_wr_c` fires when `c_wr_en`=1 and `c_mbx`=1, whatever the flag. Port C has no select input.
- R8: While a port's enable input is 0 (`a_en`, `b_rd_en` or `c_wr_en`), or while its select input is 1 (`a_sel_n`, `b_sel_n`), none of that port's strobes fire.
- R9: In any cycle, at most one strobe of a given port is 1.
- R10: While `rst_n` is 0, every output is 0, drive enables included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| clk_c | input | 1 | Port C clock |
| rst_n | input | 1 | Active-low reset, forces all outputs low |
| a_sel_n | input | 1 | Port A select, active low |
| a_dir_wr | input | 1 | Port A direction: 1 write, 0 read |
| a_en | input | 1 | Port A access enable |
| a_mbx | input | 1 | Port A target: 1 mailbox, 0 queue |
| q1_room | input | 1 | Queue 1 can accept a word |
| q2_avail_a | input | 1 | Queue 2 has a word ready for port A |
| b_sel_n | input | 1 | Port B select, active low |
| b_rd_en | input | 1 | Port B read enable |
| b_mbx | input | 1 | Port B target: 1 mailbox, 0 queue |
| q1_avail_b | input | 1 | Queue 1 has a word ready for port B |
| c_wr_en | input | 1 | Port C write enable |
| c_mbx | input | 1 | Port C target: 1 mailbox, 0 queue |
| q2_room_c | input | 1 | Queue 2 can accept a word |
| a_drv_en | output | 1 | Port A output drive enable |
| q1_push | output | 1 | Push strobe into queue 1 from port A |
| q2_pop_a | output | 1 | Pop strobe from queue 2 to port A |
| mb1_wr_a | output | 1 | Mailbox 1 write from port A |
| mb2_rd_a | output | 1 | Mailbox 2 read to port A |
| b_drv_en | output | 1 | Port B output drive enable |
| q1_pop_b | output | 1 | Pop strobe from queue 1 to port B |
| mb1_rd_b | output | 1 | Mailbox 1 read to port B |
| q2_push_c | output | 1 | Push strobe into queue 2 from port C |
| mb2_wr_c | output | 1 | Mailbox 2 write from port C |

## Verification
The assertions check several properties on every cycle of each port clock. No queue strobe fires while its readiness flag is low. A disabled or deselected port stays quiet. Port A never drives while it is set to write. At most one strobe per port is high at a time. During reset, every output is low. The bench covers what no single property can show: that the right strobe fires for each row of the three decode tables. It applies all combinations of the control and flag inputs of all three ports, plus a reset phase. Doing so also shows that the drive enables do not depend on the enable and mailbox inputs.

// File: rtl/tpa_pkg.sv
package tpa_pkg;
  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_Q_WR  = 3'd1,
    OP_Q_RD  = 3'd2,
    OP_MB_WR = 3'd3,
    OP_MB_RD = 3'd4
  } port_op_e;
endpackage

// File: rtl/tpa_port_a_dec.sv
module tpa_port_a_dec
  import tpa_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sel_n,
  input  logic     dir_wr,
  input  logic     en,
  input  logic     mbx,
  input  logic     room,
  input  logic     avail,
  output port_op_e op,
  output logic     drv_en
);
  logic active;
  assign active = rst_n && !sel_n && en;

  always_comb begin
    op = OP_IDLE;
    if (active) begin
      if (dir_wr) op = mbx ? OP_MB_WR : (room  ? OP_Q_WR : OP_IDLE);
      else        op = mbx ? OP_MB_RD : (avail ? OP_Q_RD : OP_IDLE);
    end
  end

  // Output drive only in read direction while selected
  assign drv_en = rst_n && !sel_n && !dir_wr;

  p_drive_read_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> (!dir_wr && !sel_n));
  p_push_needs_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_Q_WR) |-> (room && dir_wr && !mbx));
  p_pop_needs_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_Q_RD) |-> (avail && !dir_wr && !mbx));
  p_quiet_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || sel_n) |-> (op == OP_IDLE));
endmodule

// File: rtl/tpa_port_b_dec.sv
module tpa_port_b_dec
  import tpa_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sel_n,
  input  logic     rd_en,
  input  logic     mbx,
  input  logic     avail,
  output port_op_e op,
  output logic     drv_en
);
  always_comb begin
    op = OP_IDLE;
    if (rst_n && !sel_n && rd_en)
      op = mbx ? OP_MB_RD : (avail ? OP_Q_RD : OP_IDLE);
  end

  assign drv_en = rst_n && !sel_n;

  p_pop_needs_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_Q_RD) |-> (avail && !mbx));
  p_read_only_port_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(op inside {OP_Q_WR, OP_MB_WR}));
  p_quiet_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en || sel_n) |-> (op == OP_IDLE));
endmodule

// File: rtl/tpa_port_c_dec.sv
module tpa_port_c_dec
  import tpa_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  logic     mbx,
  input  logic     room,
  output port_op_e op
);
  always_comb begin
    op = OP_IDLE;
    if (rst_n && wr_en)
      op = mbx ? OP_MB_WR : (room ? OP_Q_WR : OP_IDLE);
  end

  p_push_needs_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_Q_WR) |-> (room && !mbx));
  p_write_only_port_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(op inside {OP_Q_RD, OP_MB_RD}));
  p_quiet_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (op == OP_IDLE));
endmodule

// File: rtl/tri_port_access_dec.sv
module tri_port_access_dec
  import tpa_pkg::*;
(
  input  logic clk_a,
  input  logic clk_b,
  input  logic clk_c,
  input  logic rst_n,
  input  logic a_sel_n,
  input  logic a_dir_wr,
  input  logic a_en,
  input  logic a_mbx,
  input  logic q1_room,
  input  logic q2_avail_a,
  input  logic b_sel_n,
  input  logic b_rd_en,
  input  logic b_mbx,
  input  logic q1_avail_b,
  input  logic c_wr_en,
  input  logic c_mbx,
  input  logic q2_room_c,
  output logic a_drv_en,
  output logic q1_push,
  output logic q2_pop_a,
  output logic mb1_wr_a,
  output logic mb2_rd_a,
  output logic b_drv_en,
  output logic q1_pop_b,
  output logic mb1_rd_b,
  output logic q2_push_c,
  output logic mb2_wr_c
);
  port_op_e op_a, op_b, op_c;

  tpa_port_a_dec u_pa (
    .clk(clk_a), .rst_n(rst_n), .sel_n(a_sel_n), .dir_wr(a_dir_wr),
    .en(a_en), .mbx(a_mbx), .room(q1_room), .avail(q2_avail_a),
    .op(op_a), .drv_en(a_drv_en)
  );

  tpa_port_b_dec u_pb (
    .clk(clk_b), .rst_n(rst_n), .sel_n(b_sel_n), .rd_en(b_rd_en),
    .mbx(b_mbx), .avail(q1_avail_b), .op(op_b), .drv_en(b_drv_en)
  );

  tpa_port_c_dec u_pc (
    .clk(clk_c), .rst_n(rst_n), .wr_en(c_wr_en), .mbx(c_mbx),
    .room(q2_room_c), .op(op_c)
  );

  // Operation code to per-target strobes
  assign q1_push   = (op_a == OP_Q_WR);
  assign q2_pop_a  = (op_a == OP_Q_RD);
  assign mb1_wr_a  = (op_a == OP_MB_WR);
  assign mb2_rd_a  = (op_a == OP_MB_RD);
  assign q1_pop_b  = (op_b == OP_Q_RD);
  assign mb1_rd_b  = (op_b == OP_MB_RD);
  assign q2_push_c = (op_c == OP_Q_WR);
  assign mb2_wr_c  = (op_c == OP_MB_WR);

  p_one_strobe_a_r9: assert property (@(posedge clk_a) disable iff (!rst_n)
    $onehot0({q1_push, q2_pop_a, mb1_wr_a, mb2_rd_a}));
  p_one_strobe_b_r9: assert property (@(posedge clk_b) disable iff (!rst_n)
    $onehot0({q1_pop_b, mb1_rd_b}));
  p_one_strobe_c_r9: assert property (@(posedge clk_c) disable iff (!rst_n)
    $onehot0({q2_push_c, mb2_wr_c}));
  p_mbx_write_a_r4: assert property (@(posedge clk_a) disable iff (!rst_n)
    mb1_wr_a |-> (a_mbx && a_dir_wr && a_en && !a_sel_n));

  // Reset silences every output
  always_comb begin
    if (!rst_n)
      p_quiet_in_reset_r10: assert ({a_drv_en, b_drv_en, q1_push, q2_pop_a, mb1_wr_a,
              mb2_rd_a, q1_pop_b, mb1_rd_b, q2_push_c, mb2_wr_c} == 10'd0);
  end
endmodule

// File: tb/sim_tri_port_access_dec.sv
module sim_tri_port_access_dec;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic clk = 1'b0;
  logic rst_n;
  logic a_sel_n, a_dir_wr, a_en, a_mbx, q1_room, q2_avail_a;
  logic b_sel_n, b_rd_en, b_mbx, q1_avail_b;
  logic c_wr_en, c_mbx, q2_room_c;
  logic a_drv_en, q1_push, q2_pop_a, mb1_wr_a, mb2_rd_a;
  logic b_drv_en, q1_pop_b, mb1_rd_b, q2_push_c, mb2_wr_c;

  always #(CLK_PERIOD/2) clk = ~clk;

  tri_port_access_dec u0 (
    .clk_a(clk), .clk_b(clk), .clk_c(clk), .rst_n(rst_n),
    .a_sel_n(a_sel_n), .a_dir_wr(a_dir_wr), .a_en(a_en), .a_mbx(a_mbx),
    .q1_room(q1_room), .q2_avail_a(q2_avail_a),
    .b_sel_n(b_sel_n), .b_rd_en(b_rd_en), .b_mbx(b_mbx), .q1_avail_b(q1_avail_b),
    .c_wr_en(c_wr_en), .c_mbx(c_mbx), .q2_room_c(q2_room_c),
    .a_drv_en(a_drv_en), .q1_push(q1_push), .q2_pop_a(q2_pop_a),
    .mb1_wr_a(mb1_wr_a), .mb2_rd_a(mb2_rd_a), .b_drv_en(b_drv_en),
    .q1_pop_b(q1_pop_b), .mb1_rd_b(mb1_rd_b), .q2_push_c(q2_push_c),
    .mb2_wr_c(mb2_wr_c)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit driver_done = 1'b0;
  logic [9:0] exp_q[$];

  // bit order of the expected vector, with the requirement each one tests
  string out_name [10] = '{"a_drv_en", "q1_push", "q2_pop_a", "mb1_wr_a", "mb2_rd_a",
                           "b_drv_en", "q1_pop_b", "mb1_rd_b", "q2_push_c", "mb2_wr_c"};
  string out_req  [10] = '{"R1", "R2", "R3", "R4", "R4", "R5", "R6", "R6", "R7", "R7"};

  function automatic logic [9:0] model(input logic [13:0] s, input logic rst);
    logic sa, wa, ea, ma, ra, va, sb, eb, mb, vb, ec, mc, rc;
    logic [9:0] e;
    {sa, wa, ea, ma, ra, va, sb, eb, mb, vb, ec, mc, rc} = s[12:0];
    e[0] = !sa && !wa;                        // R1
    e[1] = !sa && ea && wa && !ma && ra;      // R2
    e[2] = !sa && ea && !wa && !ma && va;     // R3
    e[3] = !sa && ea && wa && ma;             // R4
    e[4] = !sa && ea && !wa && ma;            // R4
    e[5] = !sb;                               // R5
    e[6] = !sb && eb && !mb && vb;            // R6
    e[7] = !sb && eb && mb;                   // R6
    e[8] = ec && !mc && rc;                   // R7
    e[9] = ec && mc;                          // R7
    if (!rst) e = '0;                         // R10
    return e;
  endfunction

  task automatic drive(input logic [13:0] s, input logic rst);
    @(negedge clk);
    rst_n = rst;
    {a_sel_n, a_dir_wr, a_en, a_mbx, q1_room, q2_avail_a,
     b_sel_n, b_rd_en, b_mbx, q1_avail_b, c_wr_en, c_mbx, q2_room_c} = s[12:0];
    exp_q.push_back(model(s, rst));
  endtask

  // Monitor: compare a quarter period after each drive, well away from the edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) begin
        logic [9:0] exp_v, act_v;
        logic in_rst;
        exp_v = exp_q.pop_front();
        in_rst = !rst_n;
        act_v = {mb2_wr_c, q2_push_c, mb1_rd_b, q1_pop_b, b_drv_en,
                 mb2_rd_a, mb1_wr_a, q2_pop_a, q1_push, a_drv_en};
        for (int i = 0; i < 10; i++) begin
          n_checks++;
          if (act_v[i] !== exp_v[i]) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", in_rst ? "R10" : out_req[i],
                     out_name[i], act_v[i], exp_v[i]);
          end
        end
        // R8 and R9 judged on the same sample
        n_checks++;
        if ((act_v[4:1] != 4'd0 && (a_sel_n || !a_en)) ||
            (act_v[7:6] != 2'd0 && (b_sel_n || !b_rd_en)) ||
            (act_v[9:8] != 2'd0 && !c_wr_en)) begin
          n_fail++;
          $display("FAIL R8: actual strobes %b expected none for disabled ports", act_v);
        end
        n_checks++;
        if ($countones(act_v[4:1]) > 1 || $countones(act_v[7:6]) > 1 ||
            $countones(act_v[9:8]) > 1) begin
          n_fail++;
          $display("FAIL R9: actual strobes %b expected at most one per port", act_v);
        end
      end
    end
  end

  // Driver
  initial begin
    rst_n = 1'b0;
    {a_sel_n, a_dir_wr, a_en, a_mbx, q1_room, q2_avail_a,
     b_sel_n, b_rd_en, b_mbx, q1_avail_b, c_wr_en, c_mbx, q2_room_c} = '0;
    // R10: inputs requesting every kind of access while held in reset
    drive(14'b0_0011110111111, 1'b0);
    drive(14'b0_0001110111111, 1'b0);
    drive(14'b0_0110110101111, 1'b0);
    // All input combinations of all three ports
    for (int k = 0; k < (1 << 13); k++) drive(14'(k), 1'b1);
    drive(14'b0_0011110111111, 1'b0);
    drive(14'b0, 1'b1);
    repeat (3) @(negedge clk);
    driver_done = 1'b1;
  end

  initial begin
    for (int c = 0; c < WATCHDOG_CYCLES && !driver_done; c++) @(posedge clk);
    if (!driver_done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual run still busy, expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule